// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave with Persistent Address Pointer

This block is the slave side of a two-wire serial memory that holds 256 bytes in an on-chip register array. A single word-address pointer survives from one transaction to the next. A master can therefore fetch the byte at that pointer with a bare read header and no address phase. A write transaction loads the pointer from a word-address byte and then stores data bytes at successive locations inside one 8-byte page.

The clock and data lines arrive already sampled into the system clock domain. The block detects start and stop conditions and the bit clock edges itself. It drives the data line only through an open-drain enable: when `sda_oe` is 1 the line is pulled low, and when it is 0 the line is released. The pointer changes in two different ways. A read steps it through all 256 addresses and wraps from 0xFF to 0x00. A write rolls only its low three bits, so the pointer stays inside the current page.

Top module: `eep_ptr_slave`

## Requirements
- R1: After reset `sda_oe` is 0, the pointer is 0x00 and every array byte reads 0x00.
- R2: The first byte after a start is the device header, sent MSB first: bits [7:4] = 1010, bits [3:1] = `dev_sel_i`, bit [0] = direction (1 = read, 0 = write). On a matching header the slave pulls SDA low during the 9th SCL clock.
- R3: A header whose code field or select field does not match gets no acknowledge. SDA then stays released for every following clock until the next start.
- R4: A read header with no address phase is followed by the byte at the current pointer, shifted out MSB first with one bit per SCL clock.
- R5: During a read the pointer advances by one on the SCL falling edge that ends the 8th data bit. The step covers all 8 bits, so 0xFF is followed by 0x00.
- R6: If the master acknowledges a read byte, the next byte follows at once. If the master does not acknowledge, the slave releases SDA and the transfer ends at the stop.
- R7: In a write, the first byte after the header loads the pointer. Each later data byte is acknowledged and placed at the pointer. After each data byte only pointer bits [2:0] advance, modulo 8, and bits [7:3] are held. A later byte aimed at the same slot replaces the earlier one.
- R8: Write data reaches the array only when a stop arrives. A start that comes before the stop discards the pending bytes.
- R9: The pointer keeps its value between transactions. A read header resumes at the address left by the last read or write.
- R10: A start at any point, including in the middle of a byte, abandons the current transfer and returns the slave to header reception. A word address that was already accepted stays loaded.
- R11: The slave asserts SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Sampled serial clock line |
| sda_i | input | 1 | Sampled serial data line (the wired level) |
| dev_sel_i | input | 3 | Strap value compared with header bits [3:1] |
| sda_oe | output | 1 | Open-drain pull-down enable for the data line |

## Verification
The bench aims at the point where read and write differ in how the pointer wraps. It writes ten bytes from 0x1E and expects later bytes to overwrite earlier ones inside the 0x18 page. It then reads across 0xFF into 0x00. A design that used the full 8-bit step for writes would spill into 0x20, and one that rolled within the page on reads would return the byte at 0xF8 instead of the byte at 0x00.

Pending write data is abandoned with a repeated start and then read back. A design that wrote the array on every byte would show the abandoned value. A start is also issued halfway through a data byte, and the read that follows must resume at the word address that was already loaded. Mismatched headers must get no acknowledge and no pull-down on later clocks. Any stray drive would corrupt the master's next bits.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;
  localparam int PAGE_W = 3;
  localparam int SEL_W  = 3;
  localparam logic [3:0] DEV_CODE = 4'b1010;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] data_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WORD,
    ST_WDAT,
    ST_RDAT
  } xfer_st_e;

  // read stepping: plain modulo-256 increment
  function automatic addr_t ptr_after_read(addr_t p);
    return p + addr_t'(1);
  endfunction

  // write stepping: page part frozen, slot part rolls
  function automatic addr_t ptr_after_write(addr_t p);
    logic [PAGE_W-1:0] slot;
    slot = p[PAGE_W-1:0] + 1'b1;
    return {p[ADDR_W-1:PAGE_W], slot};
  endfunction

  function automatic logic dev_match(data_t hdr, logic [SEL_W-1:0] sel);
    return (hdr[7:4] == DEV_CODE) && (hdr[3:1] == sel);
  endfunction
endpackage

// File: rtl/eep_line_mon.sv
module eep_line_mon (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic scl_q;
  logic sda_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise  = scl_i & ~scl_q;
  assign scl_fall  = ~scl_i & scl_q;
  assign start_evt = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_evt  = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/eep_addr_ptr.sv
module eep_addr_ptr
  import eep_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  addr_t load_val,
  input  logic  rd_adv,
  input  logic  wr_adv,
  output addr_t ptr
);
  always_ff @(posedge clk) begin
    if (!rst_n)      ptr <= '0;
    else if (load)   ptr <= load_val;
    else if (rd_adv) ptr <= ptr_after_read(ptr);
    else if (wr_adv) ptr <= ptr_after_write(ptr);
  end
endmodule

// File: rtl/eep_store.sv
module eep_store
  import eep_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int PW = PAGE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stage_we,
  input  logic [AW-1:0] stage_addr,
  input  logic [DW-1:0] stage_data,
  input  logic          drop,
  input  logic          commit,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          commit_fire
);
  localparam int DEPTH = 1 << AW;
  localparam int SLOTS = 1 << PW;

  logic [DW-1:0]    mem   [DEPTH];
  logic [DW-1:0]    pbuf  [SLOTS];
  logic [SLOTS-1:0] pvalid;
  logic [AW-PW-1:0] pbase;

  assign commit_fire = commit & (|pvalid);
  assign rd_data     = mem[rd_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      for (int j = 0; j < SLOTS; j++) pbuf[j] <= '0;
      pvalid <= '0;
      pbase  <= '0;
    end else begin
      if (commit_fire) begin
        for (int k = 0; k < SLOTS; k++) begin
          if (pvalid[k]) mem[{pbase, PW'(k)}] <= pbuf[k];
        end
      end
      if (commit || drop) begin
        pvalid <= '0;
      end else if (stage_we) begin
        pbuf[stage_addr[PW-1:0]]   <= stage_data;
        pvalid[stage_addr[PW-1:0]] <= 1'b1;
        pbase                      <= stage_addr[AW-1:PW];
      end
    end
  end
endmodule

// File: rtl/eep_xfer_fsm.sv
module eep_xfer_fsm
  import eep_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_evt,
  input  logic             stop_evt,
  input  logic             sda_in,
  input  logic [SEL_W-1:0] sel,
  input  data_t            rd_byte,
  output logic             sda_oe,
  output logic             ptr_load,
  output addr_t            ptr_load_val,
  output logic             rd_adv,
  output logic             wr_adv,
  output logic             stage_we,
  output data_t            stage_data,
  output logic             drop,
  output logic             commit,
  output logic             dev_miss,
  output xfer_st_e         state
);
  localparam logic [3:0] LAST_BIT = 4'd8;
  localparam logic [3:0] ACK_BIT  = 4'd9;

  logic [3:0] cnt;
  data_t      sr;
  data_t      obyte;
  logic       rd_dir;
  logic       mack;
  logic       byte_done;
  logic       ack_done;

  assign byte_done = scl_fall && (cnt == LAST_BIT);
  assign ack_done  = scl_fall && (cnt == ACK_BIT);

  assign dev_miss     = (state == ST_DEV)  && byte_done && !dev_match(sr, sel);
  assign ptr_load     = (state == ST_WORD) && byte_done;
  assign ptr_load_val = sr;
  assign stage_we     = (state == ST_WDAT) && byte_done;
  assign wr_adv       = stage_we;
  assign stage_data   = sr;
  assign rd_adv       = (state == ST_RDAT) && byte_done;
  assign drop         = start_evt;
  assign commit       = stop_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      sr     <= '0;
      obyte  <= '0;
      rd_dir <= 1'b0;
      mack   <= 1'b0;
      sda_oe <= 1'b0;
    end else if (start_evt) begin
      state  <= ST_DEV;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else if (stop_evt) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else if (state != ST_IDLE) begin
      if (scl_rise) begin
        if (cnt < LAST_BIT) sr <= {sr[DATA_W-2:0], sda_in};
        if (cnt == LAST_BIT && state == ST_RDAT) mack <= ~sda_in;
        if (cnt < ACK_BIT) cnt <= cnt + 4'd1;
      end else if (byte_done) begin
        if (state == ST_RDAT) begin
          sda_oe <= 1'b0;                 // hand the line to the master
        end else if (dev_miss) begin
          state  <= ST_IDLE;
          sda_oe <= 1'b0;
        end else begin
          sda_oe <= 1'b1;                 // acknowledge
          if (state == ST_DEV) rd_dir <= sr[0];
        end
      end else if (ack_done) begin
        cnt <= '0;
        unique case (state)
          ST_DEV: begin
            if (rd_dir) begin
              state  <= ST_RDAT;
              obyte  <= rd_byte;
              sda_oe <= ~rd_byte[DATA_W-1];
            end else begin
              state  <= ST_WORD;
              sda_oe <= 1'b0;
            end
          end
          ST_WORD: begin
            state  <= ST_WDAT;
            sda_oe <= 1'b0;
          end
          ST_RDAT: begin
            if (mack) begin
              obyte  <= rd_byte;
              sda_oe <= ~rd_byte[DATA_W-1];
            end else begin
              state  <= ST_IDLE;
              sda_oe <= 1'b0;
            end
          end
          default: sda_oe <= 1'b0;
        endcase
      end else if (scl_fall && state == ST_RDAT && cnt != 4'd0) begin
        obyte  <= {obyte[DATA_W-2:0], 1'b0};
        sda_oe <= ~obyte[DATA_W-2];
      end
    end
  end
endmodule

// File: rtl/eep_ptr_slave.sv
module eep_ptr_slave
  import eep_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic [SEL_W-1:0] dev_sel_i,
  output logic             sda_oe
);
  logic     scl_rise;
  logic     scl_fall;
  logic     start_evt;
  logic     stop_evt;
  logic     ptr_load;
  addr_t    ptr_load_val;
  logic     rd_adv;
  logic     wr_adv;
  logic     stage_we;
  data_t    stage_data;
  logic     drop;
  logic     commit;
  logic     dev_miss;
  logic     commit_fire;
  xfer_st_e state;
  addr_t    ptr;
  data_t    rd_byte;

  eep_line_mon u_mon (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  eep_xfer_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_rise     (scl_rise),
    .scl_fall     (scl_fall),
    .start_evt    (start_evt),
    .stop_evt     (stop_evt),
    .sda_in       (sda_i),
    .sel          (dev_sel_i),
    .rd_byte      (rd_byte),
    .sda_oe       (sda_oe),
    .ptr_load     (ptr_load),
    .ptr_load_val (ptr_load_val),
    .rd_adv       (rd_adv),
    .wr_adv       (wr_adv),
    .stage_we     (stage_we),
    .stage_data   (stage_data),
    .drop         (drop),
    .commit       (commit),
    .dev_miss     (dev_miss),
    .state        (state)
  );

  eep_addr_ptr u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ptr_load),
    .load_val (ptr_load_val),
    .rd_adv   (rd_adv),
    .wr_adv   (wr_adv),
    .ptr      (ptr)
  );

  eep_store u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .stage_we    (stage_we),
    .stage_addr  (ptr),
    .stage_data  (stage_data),
    .drop        (drop),
    .commit      (commit),
    .rd_addr     (ptr),
    .rd_data     (rd_byte),
    .commit_fire (commit_fire)
  );
endmodule

// File: rtl/eep_ptr_slave_chk.sv
module eep_ptr_slave_chk
  import eep_pkg::*;
(
  input logic     clk,
  input logic     rst_n,
  input logic     scl_i,
  input logic     sda_oe,
  input logic     start_evt,
  input logic     stop_evt,
  input logic     rd_adv,
  input logic     wr_adv,
  input logic     ptr_load,
  input addr_t    ptr,
  input logic     dev_miss,
  input logic     commit_fire,
  input xfer_st_e state
);
  AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_i);                                                 // R11

  AST_READ_FULL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    rd_adv |=> ptr == addr_t'($past(ptr) + 1'b1));                             // R5

  AST_WRITE_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_adv |=> (ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W])) &&
               (ptr[PAGE_W-1:0] == PAGE_W'($past(ptr[PAGE_W-1:0]) + 1'b1)));   // R7

  AST_PTR_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_adv || wr_adv || ptr_load) |=> $stable(ptr));                         // R9

  AST_MISS_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    dev_miss |=> !sda_oe && state == ST_IDLE);                                 // R3

  AST_START_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !sda_oe && state == ST_DEV);                                 // R10

  AST_COMMIT_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    commit_fire |-> stop_evt);                                                 // R8
endmodule

bind eep_ptr_slave eep_ptr_slave_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .scl_i       (scl_i),
  .sda_oe      (sda_oe),
  .start_evt   (start_evt),
  .stop_evt    (stop_evt),
  .rd_adv      (rd_adv),
  .wr_adv      (wr_adv),
  .ptr_load    (ptr_load),
  .ptr         (ptr),
  .dev_miss    (dev_miss),
  .commit_fire (commit_fire),
  .state       (state)
);

// File: tb/eep_ptr_slave_tb.sv
module eep_ptr_slave_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       m_sda = 1'b1;
  logic       sda_oe;
  logic [2:0] sel = 3'b101;
  logic       sda_line;

  assign sda_line = m_sda & ~sda_oe;

  always #5 clk = ~clk;

  eep_ptr_slave u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl),
    .sda_i     (sda_line),
    .dev_sel_i (sel),
    .sda_oe    (sda_oe)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [7:0] mdl_mem [256];
  logic [7:0] mdl_ptr = 8'h00;
  logic [7:0] exp_q [$];
  logic [7:0] got_q [$];
  string      tag_q [$];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic hold();
    repeat (4) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; hold();
    scl = 1'b1;   hold();
    m_sda = 1'b0; hold();
    scl = 1'b0;   hold();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; hold();
    scl = 1'b1;   hold();
    m_sda = 1'b1; hold();
  endtask

  task automatic put_bit(input logic b);
    m_sda = b; hold();
    scl = 1'b1; hold();
    scl = 1'b0; hold();
  endtask

  task automatic get_bit(output logic b);
    m_sda = 1'b1; hold();
    scl = 1'b1;
    repeat (2) @(negedge clk);
    b = sda_line;
    repeat (2) @(negedge clk);
    scl = 1'b0; hold();
  endtask

  task automatic send_byte(input logic [7:0] v, output bit acked);
    logic a;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(a);
    acked = (a == 1'b0);
  endtask

  task automatic recv_byte(output logic [7:0] v, input bit master_ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(!master_ack);
  endtask

  function automatic logic [7:0] page_step(input logic [7:0] p);
    return (p & 8'hF8) | ((p + 8'd1) & 8'h07);
  endfunction

  // driver: write header, word address, n bytes base+k
  task automatic do_write(input logic [7:0] wa, input int n, input logic [7:0] base, input bit stop);
    bit         ack;
    logic [7:0] pend [8];
    bit         pv [8];
    logic [7:0] p;
    for (int i = 0; i < 8; i++) pv[i] = 1'b0;
    bus_start();
    send_byte({4'b1010, sel, 1'b0}, ack);
    chk(ack, "R2", "write header ack", ack, 1);
    send_byte(wa, ack);
    chk(ack, "R7", "word address ack", ack, 1);
    p = wa;
    for (int k = 0; k < n; k++) begin
      send_byte(base + 8'(k), ack);
      chk(ack, "R7", "data byte ack", ack, 1);
      pend[p[2:0]] = base + 8'(k);
      pv[p[2:0]] = 1'b1;
      p = page_step(p);
    end
    mdl_ptr = p;
    if (stop) begin
      bus_stop();
      for (int i = 0; i < 8; i++)
        if (pv[i]) mdl_mem[{wa[7:3], 3'(i)}] = pend[i];
    end
  endtask

  // driver: read header, n bytes, master acks all but the last
  task automatic do_read(input int n, input string tag);
    bit         ack;
    logic [7:0] v;
    bus_start();
    send_byte({4'b1010, sel, 1'b1}, ack);
    chk(ack, "R2", "read header ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      exp_q.push_back(mdl_mem[mdl_ptr]);
      tag_q.push_back(tag);
      mdl_ptr = mdl_ptr + 8'd1;
      recv_byte(v, k < n - 1);
      got_q.push_back(v);
    end
    chk(sda_oe == 1'b0, "R6", "line released after no-ack", sda_oe, 0);
    bus_stop();
  endtask

  // monitor: pops received bytes and compares with scoreboard
  initial begin
    logic [7:0] g;
    logic [7:0] e;
    string      t;
    forever begin
      @(negedge clk);
      if (got_q.size() > 0) begin
        g = got_q.pop_front();
        if (exp_q.size() == 0) begin
          n_chk++; n_fail++;
          $display("FAIL scoreboard: unexpected byte actual=%0h expected=none", g);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(g === e, t, "read byte", g, e);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    bit   ack;
    logic b;
    int   lows;
    for (int i = 0; i < 256; i++) mdl_mem[i] = 8'h00;
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    hold();
    chk(sda_oe == 1'b0, "R1", "sda_oe after reset", sda_oe, 0);

    // R1 / R4: bare read from reset pointer
    do_read(2, "R1");

    // R3: wrong code field, then nothing driven for 9 clocks
    bus_start();
    send_byte(8'b1001_101_1, ack);
    chk(!ack, "R3", "bad code ack", ack, 0);
    lows = 0;
    for (int i = 0; i < 9; i++) begin
      get_bit(b);
      if (b == 1'b0) lows++;
    end
    chk(lows == 0, "R3", "low bits after miss", lows, 0);

    // R3: wrong select field
    bus_start();
    send_byte(8'b1010_011_0, ack);
    chk(!ack, "R3", "bad select ack", ack, 0);
    bus_stop();

    // R9: pointer untouched by mismatches, still at 2
    do_read(1, "R9");

    do_write(8'h00, 1, 8'hC3, 1'b1);
    do_write(8'h10, 5, 8'hA0, 1'b1);
    do_read(1, "R9");                    // resumes at 0x15
    do_write(8'h10, 0, 8'h00, 1'b0);
    do_read(6, "R6");                    // sequential A0..A4,00

    // R7: page roll with overwrite
    do_write(8'h1E, 10, 8'h30, 1'b1);
    do_read(1, "R7");                    // pointer at 0x18
    do_write(8'h1E, 0, 8'h00, 1'b0);
    do_read(4, "R7");

    // R5: read crosses 0xFF into 0x00
    do_write(8'hFE, 2, 8'h5A, 1'b1);
    do_write(8'hFE, 0, 8'h00, 1'b0);
    do_read(3, "R5");

    // R8: pending data dropped by repeated start
    do_write(8'h40, 1, 8'h11, 1'b0);
    do_read(1, "R8");
    do_write(8'h40, 0, 8'h00, 1'b0);
    do_read(1, "R8");

    // R10: start in the middle of a data byte
    do_write(8'h50, 1, 8'h77, 1'b1);
    bus_start();
    send_byte({4'b1010, sel, 1'b0}, ack);
    chk(ack, "R10", "header before abort", ack, 1);
    send_byte(8'h50, ack);
    chk(ack, "R10", "word address before abort", ack, 1);
    for (int i = 0; i < 4; i++) put_bit(1'b1);
    mdl_ptr = 8'h50;
    do_read(2, "R10");

    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R4", "scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule